// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a small synchronous static RAM whose bus protocol lets reads and writes follow each other on every clock with no idle cycle in between. Each active rising edge samples the command: address, three chip selects, write enable, per-byte write enables, a load/continue select and a clock enable. Write data does not travel with its command. It is sampled later, as many cycles after the command as a read needs to return its data. Because of this, the data bus carries a steady stream of transfers whatever mix of commands is issued.

A static mode input picks one of two timings. In registered-output timing, read data comes from an output register one edge after the array lookup, and write data trails its command by two edges. In flow-through timing, read data comes straight from the array after the command edge, and write data trails by one edge. Because write data arrives late, a read can find the same word still waiting for a write that has not reached the array. The block merges the arriving write bytes into that read. A continue command repeats the kind of the last load and steps the low two address bits, wrapping within a group of four words.

Top module: `lwsram`

## Requirements
- R1: A load cycle (`advLd`=0, `clkEnN`=0) selects the device only when `ce1N`=0, `ce2`=1 and `ce3N`=0. Any other combination is a deselect: nothing is read, nothing is written, and the bus stays undriven.
- R2: A selected load with `weN`=1 is a read of word `addr`. A selected load with `weN`=0 is a write to word `addr`.
- R3: With `flowMode`=0, read data for a command accepted at edge k is driven (`rdDrive`=1, `rdData` valid) after the next accepted edge, and not after edge k itself.
- R4: With `flowMode`=0, write data for a command accepted at edge k is sampled from `wrData` at the second accepted edge after k. With `flowMode`=1 it is sampled at the first accepted edge after k.
- R5: With `flowMode`=1, read data is driven directly after the accepted command edge.
- R6: Byte b is bits [9b+8:9b] of the data word and is written only when `byteEnN[b]`=0. With all `byteEnN` bits high, a write is an abort: the array does not change and the bus is not driven.
- R7: An edge with `clkEnN`=1 is ignored, and all state holds. A read being driven keeps driving the same data. A pending write stays undriven, and its data slot moves later by one edge for each stalled edge.
- R8: The bus is never driven for a write slot. `oeN`=1 forces `rdDrive`=0 and `rdData`=0 at once, without waiting for a clock edge. Whenever `rdDrive`=0, `rdData` is 0.
- R9: A continue cycle (`advLd`=1) repeats the kind of the last load, ignores the chip selects, and uses the last address with its bits [1:0] incremented modulo 4 while the upper bits stay the same. A write continue takes the current `byteEnN`.
- R10: A continue that follows a deselect load is itself a deselect.
- R11: With `flowMode`=0, a read whose address matches the write being completed at the same edge returns that write's enabled bytes merged over the older array contents.
- R12: An aborted write continue still advances the burst address.
- R13: After reset, `rdDrive`=0, `rdData`=0, and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flowMode | input | 1 | Static timing select: 1 flow-through, 0 registered output |
| clkEnN | input | 1 | Clock enable, active low; high ignores the edge |
| ce1N | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3N | input | 1 | Chip select, active low |
| advLd | input | 1 | 0 loads a new command, 1 continues the burst |
| weN | input | 1 | Write enable on load, active low |
| byteEnN | input | NUM_BYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address for load cycles |
| wrData | input | NUM_BYTES*BYTE_W | Late write data |
| oeN | input | 1 | Output enable, active low, not clocked |
| rdData | output | NUM_BYTES*BYTE_W | Read data, zero when not driven |
| rdDrive | output | 1 | Bus drive enable for read data |

## Verification
The hardest case to reach is a registered-timing read of a word whose partial write is finishing at the same edge. In that case the array still holds the old bytes, and only the forwarding path can return the right word. The stimulus creates it by issuing a one-byte write and, on the very next edge, a read of the same address, then supplying the write data on the edge after that. The other demanding sequences are stalls inserted between a write command and its data, and a burst in which one continue is aborted while the address must still advance.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmdKind_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic adv;        // this edge is accepted
    logic flow;       // flow-through timing
    logic rdCapture;  // register the looked-up word into the output register
    logic wrCommit;   // the write slot is completed at this edge
    logic busRead;    // the slot facing the bus is a read
  } strobes_t;

endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flowMode,
  input  logic                 clkEnN,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 ce3N,
  input  logic                 advLd,
  input  logic                 weN,
  input  logic [NUM_BYTES-1:0] byteEnN,
  input  logic [ADDR_W-1:0]    addr,
  output strobes_t             stb,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [NUM_BYTES-1:0] wrMask
);

  logic                 selected;
  cmdKind_e             burstKind, nextKind, slotKind;
  logic [ADDR_W-1:0]    burstAddr, nextAddr;
  logic [NUM_BYTES-1:0] nextMask;

  cmdKind_e             s1Kind, s2Kind;
  logic [ADDR_W-1:0]    s1Addr, s2Addr;
  logic [NUM_BYTES-1:0] s1Mask, s2Mask;

  always_comb begin
    selected = !ce1N && ce2 && !ce3N;
    nextAddr = burstAddr;
    nextKind = burstKind;
    if (!advLd) begin
      nextAddr = addr;
      if (!selected)  nextKind = CMD_NONE;
      else if (weN)   nextKind = CMD_READ;
      else            nextKind = CMD_WRITE;
    end else begin
      nextAddr[1:0] = burstAddr[1:0] + 2'd1;
    end
    nextMask = (nextKind == CMD_WRITE) ? ~byteEnN : '0;
    // an empty byte mask turns the slot into a no-op but keeps the burst kind
    slotKind = (nextKind == CMD_WRITE && nextMask == '0) ? CMD_NONE : nextKind;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstKind <= CMD_NONE;
      burstAddr <= '0;
      s1Kind    <= CMD_NONE;
      s1Addr    <= '0;
      s1Mask    <= '0;
      s2Kind    <= CMD_NONE;
      s2Addr    <= '0;
      s2Mask    <= '0;
    end else if (!clkEnN) begin
      burstKind <= nextKind;
      burstAddr <= nextAddr;
      s1Kind    <= slotKind;
      s1Addr    <= nextAddr;
      s1Mask    <= nextMask;
      s2Kind    <= s1Kind;
      s2Addr    <= s1Addr;
      s2Mask    <= s1Mask;
    end
  end

  always_comb begin
    stb.adv       = !clkEnN;
    stb.flow      = flowMode;
    stb.rdCapture = !flowMode && (s1Kind == CMD_READ);
    stb.wrCommit  = flowMode ? (s1Kind == CMD_WRITE) : (s2Kind == CMD_WRITE);
    stb.busRead   = flowMode ? (s1Kind == CMD_READ)  : (s2Kind == CMD_READ);
    rdAddr        = s1Addr;
    wrAddr        = flowMode ? s1Addr : s2Addr;
    wrMask        = flowMode ? s1Mask : s2Mask;
  end

endmodule

// File: rtl/lwsram_datapath.sv
module lwsram_datapath
  import lwsram_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobes_t                    stb,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [NUM_BYTES-1:0]        wrMask,
  input  logic [NUM_BYTES*BYTE_W-1:0] wrData,
  input  logic                        oeN,
  output logic [NUM_BYTES*BYTE_W-1:0] rdData,
  output logic                        rdDrive
);

  localparam int DATA_W = NUM_BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] arrayWord, mergedWord, outReg;
  logic              addrHit, driveNow;

  assign arrayWord = mem[rdAddr];
  assign addrHit   = stb.wrCommit && (wrAddr == rdAddr);

  // bytes completing at this edge override the stale array contents
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_merge
    assign mergedWord[b*BYTE_W +: BYTE_W] =
      (addrHit && wrMask[b]) ? wrData[b*BYTE_W +: BYTE_W] : arrayWord[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (stb.adv && stb.wrCommit) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (wrMask[b]) mem[wrAddr][b*BYTE_W +: BYTE_W] <= wrData[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         outReg <= '0;
    else if (stb.adv && stb.rdCapture) outReg <= mergedWord;
  end

  assign driveNow = stb.busRead && !oeN;
  assign rdDrive  = driveNow;
  assign rdData   = driveNow ? (stb.flow ? mergedWord : outReg) : '0;

endmodule

// File: rtl/lwsram.sv
module lwsram
  import lwsram_pkg::*;
#(
  parameter int ADDR_W    = 4,   // at least 2: the burst steps bits [1:0]
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flowMode,
  input  logic                        clkEnN,
  input  logic                        ce1N,
  input  logic                        ce2,
  input  logic                        ce3N,
  input  logic                        advLd,
  input  logic                        weN,
  input  logic [NUM_BYTES-1:0]        byteEnN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_BYTES*BYTE_W-1:0] wrData,
  input  logic                        oeN,
  output logic [NUM_BYTES*BYTE_W-1:0] rdData,
  output logic                        rdDrive
);

  strobes_t             stb;
  logic [ADDR_W-1:0]    rdAddr, wrAddr;
  logic [NUM_BYTES-1:0] wrMask;

  lwsram_ctrl #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .flowMode(flowMode), .clkEnN(clkEnN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .advLd(advLd), .weN(weN),
    .byteEnN(byteEnN), .addr(addr),
    .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr), .wrMask(wrMask)
  );

  lwsram_datapath #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrMask(wrMask), .wrData(wrData), .oeN(oeN),
    .rdData(rdData), .rdDrive(rdDrive)
  );

endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
  parameter int NUM_BYTES = 4,
  parameter int DATA_W    = 36
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 flowMode,
  input logic                 clkEnN,
  input logic                 ce1N,
  input logic                 ce2,
  input logic                 ce3N,
  input logic                 advLd,
  input logic                 weN,
  input logic [NUM_BYTES-1:0] byteEnN,
  input logic                 oeN,
  input logic [DATA_W-1:0]    rdData,
  input logic                 rdDrive
);

  logic selLoad, loadRead, loadWrite, deselLoad, pipeArm;

  assign selLoad   = !clkEnN && !advLd && !ce1N && ce2 && !ce3N;
  assign loadRead  = selLoad && weN;
  assign loadWrite = selLoad && !weN;
  assign deselLoad = !clkEnN && !advLd && !(!ce1N && ce2 && !ce3N);

  // remembers a registered-timing read accepted at the last accepted edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pipeArm <= 1'b0;
    else if (!clkEnN) pipeArm <= !flowMode && loadRead;
  end

  // R3
  pipe_read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeArm && !clkEnN) |=> (rdDrive || oeN));

  // R5
  flow_read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && loadRead) |=> (rdDrive || oeN));

  // R8
  flow_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && loadWrite) |=> !rdDrive);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ((oeN != $past(oeN)) || ($stable(rdDrive) && $stable(rdData))));

  // R1
  flow_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flowMode && deselLoad) |=> !rdDrive);

endmodule

bind lwsram lwsram_chk #(.NUM_BYTES(NUM_BYTES), .DATA_W(NUM_BYTES*BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .flowMode(flowMode), .clkEnN(clkEnN),
  .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .advLd(advLd), .weN(weN),
  .byteEnN(byteEnN), .oeN(oeN), .rdData(rdData), .rdDrive(rdDrive)
);

// File: tb/lwsram_tb.sv
`timescale 1ns/1ps
module lwsram_tb;

  localparam int AW = 4;
  localparam int NB = 4;
  localparam int DW = 36;
  localparam logic [DW-1:0] GARB = 36'hBAD0BAD0B;

  logic          clk = 1'b0;
  logic          rstN, flowMode, clkEnN, ce1N, ce2, ce3N, advLd, weN, oeN;
  logic [NB-1:0] byteEnN;
  logic [AW-1:0] addr;
  logic [DW-1:0] wrData, rdData;
  logic          rdDrive;
  int            checks = 0;
  int            errors = 0;

  always #2.5 clk = ~clk;

  lwsram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(9)) u_dut (
    .clk(clk), .rstN(rstN), .flowMode(flowMode), .clkEnN(clkEnN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .advLd(advLd), .weN(weN),
    .byteEnN(byteEnN), .addr(addr), .wrData(wrData), .oeN(oeN),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    clkEnN = 0; advLd = 0; ce1N = 1; ce2 = 1; ce3N = 0; weN = 1; byteEnN = '1; addr = '0;
  endtask

  task automatic cmdRead(input logic [AW-1:0] a);
    clkEnN = 0; advLd = 0; ce1N = 0; ce2 = 1; ce3N = 0; weN = 1; byteEnN = '1; addr = a;
  endtask

  task automatic cmdWrite(input logic [AW-1:0] a, input logic [NB-1:0] be);
    clkEnN = 0; advLd = 0; ce1N = 0; ce2 = 1; ce3N = 0; weN = 0; byteEnN = be; addr = a;
  endtask

  // chip selects deliberately inactive: a continue must ignore them
  task automatic cmdCont(input logic [NB-1:0] be);
    clkEnN = 0; advLd = 1; ce1N = 1; ce2 = 0; ce3N = 1; weN = 1; byteEnN = be; addr = '0;
  endtask

  task automatic pokePipe(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmdWrite(a, '0); wrData = GARB; step();
    idle(); step();
    wrData = d; step();
    wrData = GARB;
  endtask

  task automatic peekPipe(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    cmdRead(a); step();
    idle(); step();
    chk({tag, " drive"}, 64'(rdDrive), 64'd1);
    chk({tag, " data"}, 64'(rdData), 64'(exp));
    step();
  endtask

  function automatic logic [DW-1:0] mergeBytes(input logic [DW-1:0] oldW, input logic [DW-1:0] newW,
                                               input logic [NB-1:0] beN);
    logic [DW-1:0] r = oldW;
    for (int b = 0; b < NB; b++) if (!beN[b]) r[b*9 +: 9] = newW[b*9 +: 9];
    return r;
  endfunction

  task automatic doReset(input logic fm);
    rstN = 0; flowMode = fm; idle(); oeN = 0; wrData = GARB;
    step(); step();
    chk("R13 reset drive", 64'(rdDrive), 64'd0);
    chk("R13 reset data", 64'(rdData), 64'd0);
    rstN = 1; step();
    chk("R13 after release drive", 64'(rdDrive), 64'd0);
  endtask

  task automatic testPipeLatency();
    pokePipe(3, 36'h0A5A5A5A5);
    cmdRead(3); step();
    chk("R3 not yet driven", 64'(rdDrive), 64'd0);
    idle(); step();
    chk("R3 driven", 64'(rdDrive), 64'd1);
    chk("R4 R2 pipe data", 64'(rdData), 64'h0A5A5A5A5);
    step();
    chk("R8 released", 64'(rdDrive), 64'd0);
    chk("R8 released data zero", 64'(rdData), 64'd0);
  endtask

  task automatic testAlternate();
    pokePipe(1, 36'h111111111);
    pokePipe(2, 36'h222222222);
    cmdWrite(1, '0); wrData = GARB; step();
    cmdRead(2); step();
    cmdWrite(4, '0); wrData = 36'h0CAFE0001; step();
    chk("R2 alt read drive", 64'(rdDrive), 64'd1);
    chk("R2 alt read data", 64'(rdData), 64'h222222222);
    cmdRead(1); wrData = GARB; step();
    chk("R8 write slot undriven", 64'(rdDrive), 64'd0);
    idle(); wrData = 36'h0BEEF0004; step();
    chk("R4 alt read back", 64'(rdData), 64'h0CAFE0001);
    wrData = GARB; step();
    chk("R3 alt idle", 64'(rdDrive), 64'd0);
    peekPipe(4, 36'h0BEEF0004, "R4 second write");
  endtask

  task automatic testCoherency();
    logic [DW-1:0] oldW = 36'h123456789;
    logic [DW-1:0] newW = 36'hFEDCBA987;
    logic [DW-1:0] expW = mergeBytes(oldW, newW, 4'b1101);
    pokePipe(7, oldW);
    cmdWrite(7, 4'b1101); wrData = GARB; step();
    cmdRead(7); step();
    idle(); wrData = newW; step();
    chk("R11 forwarded drive", 64'(rdDrive), 64'd1);
    chk("R11 forwarded merge", 64'(rdData), 64'(expW));
    wrData = GARB; step();
    peekPipe(7, expW, "R11 array merged");
  endtask

  task automatic testByteMask();
    logic [DW-1:0] oldW = 36'h0F0F0F0F0;
    logic [DW-1:0] newW = 36'h5A5A5A5A5;
    logic [DW-1:0] expW = mergeBytes(oldW, newW, 4'b0110);
    pokePipe(5, oldW);
    cmdWrite(5, 4'b0110); wrData = GARB; step();
    idle(); step();
    wrData = newW; step();
    wrData = GARB;
    peekPipe(5, expW, "R6 partial bytes");
    cmdWrite(5, 4'b1111); wrData = 36'h000000000; step();
    chk("R6 abort undriven a", 64'(rdDrive), 64'd0);
    idle(); step();
    chk("R6 abort undriven b", 64'(rdDrive), 64'd0);
    step();
    wrData = GARB;
    peekPipe(5, expW, "R6 abort no change");
  endtask

  task automatic testStall();
    pokePipe(8, 36'h088888888);
    cmdRead(8); step();
    idle(); step();
    chk("R7 read driven", 64'(rdDrive), 64'd1);
    cmdRead(3); clkEnN = 1; step();
    chk("R7 stalled drive", 64'(rdDrive), 64'd1);
    chk("R7 stalled data", 64'(rdData), 64'h088888888);
    step();
    chk("R7 stalled data 2", 64'(rdData), 64'h088888888);
    idle(); step();
    chk("R7 resumed", 64'(rdDrive), 64'd0);
    step();
    chk("R7 stalled read ignored", 64'(rdDrive), 64'd0);
    cmdWrite(8, '0); wrData = GARB; step();
    idle(); clkEnN = 1; step();
    chk("R7 stalled write undriven", 64'(rdDrive), 64'd0);
    step();
    chk("R7 stalled write undriven 2", 64'(rdDrive), 64'd0);
    clkEnN = 0; step();
    wrData = 36'h0DEF0DEF0; step();
    wrData = GARB;
    peekPipe(8, 36'h0DEF0DEF0, "R7 delayed write data");
  endtask

  task automatic testOutputEnable();
    pokePipe(9, 36'h099999999);
    oeN = 1;
    cmdRead(9); step();
    idle(); step();
    chk("R8 oe off drive", 64'(rdDrive), 64'd0);
    chk("R8 oe off data", 64'(rdData), 64'd0);
    oeN = 0; #1;
    chk("R8 oe on drive", 64'(rdDrive), 64'd1);
    chk("R8 oe on data", 64'(rdData), 64'h099999999);
    step();
  endtask

  task automatic testDeselect();
    pokePipe(10, 36'h0AAAAAAAA);
    pokePipe(11, 36'h0BBBBBBBB);
    for (int v = 0; v < 3; v++) begin
      cmdRead(10);
      if (v == 0) ce1N = 1;
      if (v == 1) ce2 = 0;
      if (v == 2) ce3N = 1;
      step();
      idle(); step();
      chk("R1 deselected read", 64'(rdDrive), 64'd0);
    end
    cmdWrite(10, '0); ce2 = 0; wrData = GARB; step();
    idle(); step();
    wrData = 36'h000000000; step();
    wrData = GARB;
    peekPipe(10, 36'h0AAAAAAAA, "R1 deselected write");
    cmdRead(10); ce1N = 1; step();
    cmdCont(4'b0000); step();
    idle(); wrData = 36'h000000000; step();
    chk("R10 continue after deselect", 64'(rdDrive), 64'd0);
    step();
    wrData = GARB;
    peekPipe(11, 36'h0BBBBBBBB, "R10 no write by continue");
  endtask

  task automatic testBurst();
    pokePipe(12, 36'h0C0C0C0C0);
    cmdWrite(14, '0); wrData = GARB; step();
    cmdCont(4'b0000); step();
    cmdCont(4'b1111); wrData = 36'h0E0E0E0E0; step();
    cmdCont(4'b0000); wrData = 36'h0F1F1F1F1; step();
    idle(); wrData = 36'h000000000; step();
    wrData = 36'h0D0D0D0D0; step();
    wrData = GARB;
    cmdRead(14); step();
    cmdCont(4'b1111); step();
    chk("R9 burst word 14", 64'(rdData), 64'h0E0E0E0E0);
    cmdCont(4'b1111); step();
    chk("R9 burst word 15", 64'(rdData), 64'h0F1F1F1F1);
    cmdCont(4'b1111); step();
    chk("R12 aborted word 12 kept", 64'(rdData), 64'h0C0C0C0C0);
    idle(); step();
    chk("R12 R9 wrapped word 13", 64'(rdData), 64'h0D0D0D0D0);
    step();
    chk("R9 burst ends", 64'(rdDrive), 64'd0);
  endtask

  task automatic testFlow();
    cmdWrite(2, '0); wrData = GARB; step();
    chk("R8 flow write undriven", 64'(rdDrive), 64'd0);
    idle(); wrData = 36'h0F2F2F2F2; step();
    cmdRead(2); wrData = GARB; step();
    chk("R5 flow drive", 64'(rdDrive), 64'd1);
    chk("R5 R4 flow data", 64'(rdData), 64'h0F2F2F2F2);
    cmdWrite(3, '0); step();
    chk("R8 flow turn to write", 64'(rdDrive), 64'd0);
    cmdRead(2); wrData = 36'h0F3F3F3F3; step();
    chk("R5 flow alternate read", 64'(rdData), 64'h0F2F2F2F2);
    cmdRead(3); wrData = GARB; step();
    chk("R4 flow single late write", 64'(rdData), 64'h0F3F3F3F3);
    clkEnN = 1; step();
    chk("R7 flow stall hold", 64'(rdData), 64'h0F3F3F3F3);
    idle(); step();
    chk("R5 flow idle", 64'(rdDrive), 64'd0);
  endtask

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; flowMode = 0; idle(); oeN = 0; wrData = GARB;
    @(negedge clk);
    doReset(1'b0);
    testPipeLatency();
    testAlternate();
    testCoherency();
    testByteMask();
    testStall();
    testOutputEnable();
    testDeselect();
    testBurst();
    doReset(1'b1);
    testFlow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule